// File: doc/BRIEF.md
# Instruction Cache Tag Directory with Counter-Based Replacement

This block is the tag side of a set-associative instruction cache. It holds no instruction bytes. For each fetch address it splits off the block offset, uses the next bits to select a set, and compares the remaining upper bits against the stored tag of every way in that set. It answers one cycle later with hit or miss and the way involved. On a miss it chooses a victim way and installs the new tag there in the same update.

Replacement is driven by a small saturating usage counter per way and per set. The number of usage states is a parameter. A way just used is loaded with the top state, and the others count down towards zero. A per-way enable mask limits which ways age on a miss and which ways may be invalidated. An invalidate request looks up an address and clears the matching way. Two saturating statistics counters record fetch hits and fetch misses, and both can be cleared.

Top module: `ictag_dir`

## Requirements
- R1: With an offset width of log2(BLOCK_BYTES) and an index width of log2(NUM_SETS), the set index is the address bits directly above the block offset, and the tag is all bits above the index. A fetch hits only if the stored tag matches in the set selected by its own index. The same tag in a different set misses.
- R2: A fetch is accepted only when `fetch_vld_i`, `present_i` and `enable_i` are all 1 in the same cycle. An accepted fetch raises `rsp_vld_o` for exactly one cycle, on the next cycle. A fetch that is not accepted produces no response and changes no directory state.
- R3: A fetch hits when a valid way of the selected set holds the lookup tag. The response then has `rsp_hit_o`=1, and `rsp_way_o` gives that way.
- R4: On a fetch hit, every way of the set whose usage counter is nonzero counts down by one, regardless of the mask. The hit way is then loaded with USE_STATES-1.
- R5: On a fetch miss, `rsp_hit_o`=0 and the new tag is written into the victim way, which becomes valid. `rsp_way_o` gives the victim. The victim is the lowest-numbered invalid way if one exists. Otherwise it is the way with the smallest usage counter, with ties going to the lower way number.
- R6: On a fetch miss, the victim's counter is loaded with USE_STATES-1. Each other way counts down only if its counter is nonzero and its bit in `way_en_i` is 1.
- R7: An invalidate is accepted when `inval_vld_i` and `present_i` are 1; `enable_i` has no effect on it. If the address hits a way whose `way_en_i` bit is 1, that way becomes invalid, and the next cycle `inv_done_o` pulses with `rsp_way_o` giving that way. Otherwise nothing changes. Usage counters are not touched by an invalidate.
- R8: When an accepted fetch and an invalidate request arrive in the same cycle, the fetch is processed and the invalidate is dropped.
- R9: Reset, synchronous and active high, makes every way invalid and every usage counter zero. It clears both statistics counters and drives `rsp_vld_o`, `rsp_hit_o` and `inv_done_o` to 0.
- R10: `hit_cnt_o` and `miss_cnt_o` each count one per accepted fetch hit or miss, with the update visible in the same cycle as its response. Each holds at its all-ones maximum instead of wrapping. `stat_clr_i` zeroes both on the next cycle, and it takes precedence over an increment in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| present_i | input | 1 | Cache is fitted; needed by every request |
| enable_i | input | 1 | Cache is switched on; needed by fetches only |
| way_en_i | input | NUM_WAYS | Per-way mask gating miss aging and invalidation |
| fetch_vld_i | input | 1 | Single-cycle fetch lookup strobe |
| inval_vld_i | input | 1 | Single-cycle invalidate strobe |
| addr_i | input | ADDR_W | Byte address of the request |
| stat_clr_i | input | 1 | Clears both statistics counters |
| rsp_vld_o | output | 1 | Fetch response valid, one cycle after acceptance |
| rsp_hit_o | output | 1 | Fetch hit flag |
| rsp_way_o | output | max(1,log2(NUM_WAYS)) | Hit, victim or invalidated way |
| inv_done_o | output | 1 | An invalidate cleared a way |
| hit_cnt_o | output | STAT_W | Saturating fetch-hit count |
| miss_cnt_o | output | STAT_W | Saturating fetch-miss count |

## Verification
The bench builds the directory with 4 sets, 16-byte blocks, 4 ways, 4 usage states, 16-bit addresses and 8-bit statistics counters. Four ways with four usage states let a short sequence fill a set, exercise the invalid-first rule, and make counter ties and mask-gated aging change which victim is chosen. Only four sets make the same tag recur across sets often. The narrow statistics counters reach their all-ones limit within a few hundred fetches, so saturation is checked directly.

// File: rtl/ictag_pkg.sv
package ictag_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_FETCH = 2'd1,
        OP_INVAL = 2'd2
    } op_e;

    typedef struct packed {
        logic fetch;
        logic hit;
        logic inval;
    } rsp_flags_t;

    // Request arbitration: a live fetch beats an invalidate.
    function automatic op_e pick_op(input logic fetch, input logic inval,
                                    input logic present, input logic enable);
        if (fetch && present && enable)
            return OP_FETCH;
        else if (inval && present)
            return OP_INVAL;
        else
            return OP_IDLE;
    endfunction

endpackage

// File: rtl/ictag_match.sv
module ictag_match #(
    parameter int NUM_WAYS = 1,
    parameter int TAG_W    = 19,
    parameter int WAY_W    = 1
) (
    input  logic [NUM_WAYS-1:0]            row_valid,
    input  logic [NUM_WAYS-1:0][TAG_W-1:0] row_tag,
    input  logic [TAG_W-1:0]               lookup_tag,
    output logic                           any_hit,
    output logic [WAY_W-1:0]               hit_way
);
    logic [NUM_WAYS-1:0] hit_vec;

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_cmp
        assign hit_vec[w] = row_valid[w] && (row_tag[w] == lookup_tag);
    end

    assign any_hit = |hit_vec;

    always_comb begin
        hit_way = '0;
        for (int w = NUM_WAYS - 1; w >= 0; w--) begin
            if (hit_vec[w])
                hit_way = WAY_W'(w);
        end
    end
endmodule

// File: rtl/ictag_victim.sv
module ictag_victim #(
    parameter int NUM_WAYS = 1,
    parameter int USE_W    = 1,
    parameter int WAY_W    = 1
) (
    input  logic [NUM_WAYS-1:0]            row_valid,
    input  logic [NUM_WAYS-1:0][USE_W-1:0] row_use,
    output logic [WAY_W-1:0]               vict_way
);
    always_comb begin
        int  best;
        logic found;
        best  = 0;
        found = 1'b0;
        for (int w = 0; w < NUM_WAYS; w++) begin
            if (!found && !row_valid[w]) begin
                best  = w;
                found = 1'b1;
            end
        end
        if (!found) begin
            for (int w = 1; w < NUM_WAYS; w++) begin
                if (row_use[w] < row_use[best])
                    best = w;
            end
        end
        vict_way = WAY_W'(best);
    end
endmodule

// File: rtl/ictag_stat.sv
module ictag_stat #(
    parameter int STAT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              inc,
    output logic [STAT_W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (inc && (cnt != {STAT_W{1'b1}}))
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/ictag_dir.sv
module ictag_dir #(
    parameter int ADDR_W      = 32,
    parameter int NUM_SETS    = 512,
    parameter int BLOCK_BYTES = 16,
    parameter int NUM_WAYS    = 1,
    parameter int USE_STATES  = 2,
    parameter int STAT_W      = 32,
    localparam int WAY_W      = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                present_i,
    input  logic                enable_i,
    input  logic [NUM_WAYS-1:0] way_en_i,
    input  logic                fetch_vld_i,
    input  logic                inval_vld_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic                stat_clr_i,
    output logic                rsp_vld_o,
    output logic                rsp_hit_o,
    output logic [WAY_W-1:0]    rsp_way_o,
    output logic                inv_done_o,
    output logic [STAT_W-1:0]   hit_cnt_o,
    output logic [STAT_W-1:0]   miss_cnt_o
);
    import ictag_pkg::*;

    localparam int OFF_W = $clog2(BLOCK_BYTES);
    localparam int IDX_W = $clog2(NUM_SETS);
    localparam int TAG_W = ADDR_W - OFF_W - IDX_W;
    localparam int USE_W = (USE_STATES > 2) ? $clog2(USE_STATES) : 1;
    localparam logic [USE_W-1:0] USE_TOP = USE_W'(USE_STATES - 1);

    // Directory storage, one row per set.
    logic [NUM_WAYS-1:0]            vld_q [NUM_SETS];
    logic [NUM_WAYS-1:0][TAG_W-1:0] tag_q [NUM_SETS];
    logic [NUM_WAYS-1:0][USE_W-1:0] use_q [NUM_SETS];

    op_e                            op;
    logic [IDX_W-1:0]               set_idx;
    logic [TAG_W-1:0]               lk_tag;
    logic [NUM_WAYS-1:0]            row_vld;
    logic [NUM_WAYS-1:0][TAG_W-1:0] row_tag;
    logic [NUM_WAYS-1:0][USE_W-1:0] row_use;
    logic                           any_hit;
    logic [WAY_W-1:0]               hit_way;
    logic [WAY_W-1:0]               vict_way;
    logic [NUM_WAYS-1:0]            nxt_vld;
    logic [NUM_WAYS-1:0][USE_W-1:0] nxt_use;
    logic                           inv_take;
    rsp_flags_t                     flags;
    logic                           unused_offset_bits;

    assign op       = pick_op(fetch_vld_i, inval_vld_i, present_i, enable_i);
    assign set_idx  = addr_i[OFF_W +: IDX_W];
    assign lk_tag   = addr_i[ADDR_W-1 -: TAG_W];
    assign row_vld  = vld_q[set_idx];
    assign row_tag  = tag_q[set_idx];
    assign row_use  = use_q[set_idx];
    assign unused_offset_bits = ^addr_i[OFF_W-1:0];

    ictag_match #(
        .NUM_WAYS (NUM_WAYS),
        .TAG_W    (TAG_W),
        .WAY_W    (WAY_W)
    ) u_match (
        .row_valid  (row_vld),
        .row_tag    (row_tag),
        .lookup_tag (lk_tag),
        .any_hit    (any_hit),
        .hit_way    (hit_way)
    );

    ictag_victim #(
        .NUM_WAYS (NUM_WAYS),
        .USE_W    (USE_W),
        .WAY_W    (WAY_W)
    ) u_victim (
        .row_valid (row_vld),
        .row_use   (row_use),
        .vict_way  (vict_way)
    );

    assign flags.fetch = (op == OP_FETCH);
    assign flags.hit   = flags.fetch && any_hit;
    assign flags.inval = (op == OP_INVAL) && any_hit && way_en_i[hit_way];
    assign inv_take    = flags.inval;

    // Next usage counters and valid bits for the addressed set.
    always_comb begin
        nxt_use = row_use;
        nxt_vld = row_vld;
        for (int w = 0; w < NUM_WAYS; w++) begin
            if (flags.hit) begin
                if (WAY_W'(w) == hit_way)
                    nxt_use[w] = USE_TOP;
                else if (row_use[w] != '0)
                    nxt_use[w] = row_use[w] - 1'b1;
            end else if (flags.fetch) begin
                if (WAY_W'(w) == vict_way) begin
                    nxt_use[w] = USE_TOP;
                    nxt_vld[w] = 1'b1;
                end else if ((row_use[w] != '0) && way_en_i[w]) begin
                    nxt_use[w] = row_use[w] - 1'b1;
                end
            end else if (inv_take && (WAY_W'(w) == hit_way)) begin
                nxt_vld[w] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NUM_SETS; s++) begin
                vld_q[s] <= '0;
                use_q[s] <= '0;
            end
        end else if (flags.fetch) begin
            vld_q[set_idx] <= nxt_vld;
            use_q[set_idx] <= nxt_use;
        end else if (inv_take) begin
            vld_q[set_idx] <= nxt_vld;
        end
    end

    // Tags need no reset: a way is only trusted once its valid bit is set.
    always_ff @(posedge clk) begin
        if (flags.fetch && !any_hit)
            tag_q[set_idx][vict_way] <= lk_tag;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_vld_o  <= 1'b0;
            rsp_hit_o  <= 1'b0;
            rsp_way_o  <= '0;
            inv_done_o <= 1'b0;
        end else begin
            rsp_vld_o  <= flags.fetch;
            rsp_hit_o  <= flags.hit;
            inv_done_o <= inv_take;
            if (flags.fetch)
                rsp_way_o <= any_hit ? hit_way : vict_way;
            else if (inv_take)
                rsp_way_o <= hit_way;
        end
    end

    ictag_stat #(.STAT_W(STAT_W)) u_hit_stat (
        .clk (clk),
        .rst (rst),
        .clr (stat_clr_i),
        .inc (flags.hit),
        .cnt (hit_cnt_o)
    );

    ictag_stat #(.STAT_W(STAT_W)) u_miss_stat (
        .clk (clk),
        .rst (rst),
        .clr (stat_clr_i),
        .inc (flags.fetch && !any_hit),
        .cnt (miss_cnt_o)
    );
endmodule

// File: rtl/ictag_dir_chk.sv
module ictag_dir_chk #(
    parameter int NUM_WAYS = 1,
    parameter int WAY_W    = 1,
    parameter int STAT_W   = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              present_i,
    input logic              enable_i,
    input logic              fetch_vld_i,
    input logic              inval_vld_i,
    input logic              stat_clr_i,
    input logic              rsp_vld_o,
    input logic              rsp_hit_o,
    input logic [WAY_W-1:0]  rsp_way_o,
    input logic              inv_done_o,
    input logic [STAT_W-1:0] hit_cnt_o,
    input logic [STAT_W-1:0] miss_cnt_o
);
    logic fetch_live;
    assign fetch_live = fetch_vld_i && present_i && enable_i;

    p_rsp_cause_r2: assert property (@(posedge clk) disable iff (rst)
        rsp_vld_o |-> $past(fetch_live));

    p_no_rsp_r2: assert property (@(posedge clk) disable iff (rst)
        !fetch_live |=> !rsp_vld_o);

    p_hit_in_rsp_r3: assert property (@(posedge clk) disable iff (rst)
        rsp_hit_o |-> rsp_vld_o);

    // R8 as well: a same-cycle fetch suppresses the invalidate
    p_inval_cause_r7: assert property (@(posedge clk) disable iff (rst)
        inv_done_o |-> $past(inval_vld_i && present_i && !fetch_live));

    p_excl_r8: assert property (@(posedge clk) disable iff (rst)
        !(inv_done_o && rsp_vld_o));

    p_clear_r10: assert property (@(posedge clk) disable iff (rst)
        stat_clr_i |=> (hit_cnt_o == '0) && (miss_cnt_o == '0));

    p_no_wrap_r10: assert property (@(posedge clk) disable iff (rst)
        !stat_clr_i |=> (hit_cnt_o >= $past(hit_cnt_o)) && (miss_cnt_o >= $past(miss_cnt_o)));

    p_miss_step_r10: assert property (@(posedge clk) disable iff (rst)
        (fetch_live && !stat_clr_i) |=>
            (rsp_hit_o || (miss_cnt_o != $past(miss_cnt_o)) || (&$past(miss_cnt_o))));

    p_rsp_way_known_r5: assert property (@(posedge clk) disable iff (rst)
        rsp_vld_o |-> !$isunknown(rsp_way_o));
endmodule

bind ictag_dir ictag_dir_chk #(
    .NUM_WAYS (NUM_WAYS),
    .WAY_W    (WAY_W),
    .STAT_W   (STAT_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .present_i   (present_i),
    .enable_i    (enable_i),
    .fetch_vld_i (fetch_vld_i),
    .inval_vld_i (inval_vld_i),
    .stat_clr_i  (stat_clr_i),
    .rsp_vld_o   (rsp_vld_o),
    .rsp_hit_o   (rsp_hit_o),
    .rsp_way_o   (rsp_way_o),
    .inv_done_o  (inv_done_o),
    .hit_cnt_o   (hit_cnt_o),
    .miss_cnt_o  (miss_cnt_o)
);

// File: tb/ictag_dir_tb.sv
module ictag_dir_tb;
    localparam int AW   = 16;
    localparam int NS   = 4;
    localparam int BB   = 16;
    localparam int NW   = 4;
    localparam int US   = 4;
    localparam int SW   = 8;
    localparam int WW   = 2;
    localparam int SMAX = (1 << SW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          present_i = 1'b1;
    logic          enable_i = 1'b1;
    logic [NW-1:0] way_en_i = '1;
    logic          fetch_vld_i = 1'b0;
    logic          inval_vld_i = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic          stat_clr_i = 1'b0;
    logic          rsp_vld_o, rsp_hit_o, inv_done_o;
    logic [WW-1:0] rsp_way_o;
    logic [SW-1:0] hit_cnt_o, miss_cnt_o;

    always #4 clk = ~clk;

    ictag_dir #(
        .ADDR_W(AW), .NUM_SETS(NS), .BLOCK_BYTES(BB),
        .NUM_WAYS(NW), .USE_STATES(US), .STAT_W(SW)
    ) u_dut (
        .clk(clk), .rst(rst), .present_i(present_i), .enable_i(enable_i),
        .way_en_i(way_en_i), .fetch_vld_i(fetch_vld_i), .inval_vld_i(inval_vld_i),
        .addr_i(addr_i), .stat_clr_i(stat_clr_i), .rsp_vld_o(rsp_vld_o),
        .rsp_hit_o(rsp_hit_o), .rsp_way_o(rsp_way_o), .inv_done_o(inv_done_o),
        .hit_cnt_o(hit_cnt_o), .miss_cnt_o(miss_cnt_o)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // Reference state built from the requirements.
    bit mv [NS][NW];
    int mt [NS][NW];
    int mu [NS][NW];
    int mh, mm;

    task automatic chk(input int act, input int exp, input string what);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    function automatic int mk_addr(input int tg, input int st, input int off);
        return (tg << 6) | (st << 4) | (off & 15);
    endfunction

    task automatic run_op(input bit f, input bit iv, input int a, input bit pr,
                          input bit en, input bit [NW-1:0] mask, input bit clr,
                          input string tg);
        int s, t, hw, v;
        bit e_vld, e_hit, e_inv;
        int e_way;
        e_vld = 0; e_hit = 0; e_inv = 0; e_way = -1;
        s = (a >> 4) % NS;
        t = a >> 6;
        hw = -1;
        for (int w = 0; w < NW; w++)
            if (hw < 0 && mv[s][w] && mt[s][w] == t) hw = w;
        if (f && pr && en) begin
            e_vld = 1;
            if (hw >= 0) begin
                e_hit = 1; e_way = hw;
                for (int w = 0; w < NW; w++) if (mu[s][w] != 0) mu[s][w]--;
                mu[s][hw] = US - 1;
                if (mh < SMAX) mh++;
            end else begin
                v = -1;
                for (int w = 0; w < NW; w++) if (v < 0 && !mv[s][w]) v = w;
                if (v < 0) begin
                    v = 0;
                    for (int w = 1; w < NW; w++) if (mu[s][w] < mu[s][v]) v = w;
                end
                e_way = v;
                mt[s][v] = t; mv[s][v] = 1;
                for (int w = 0; w < NW; w++)
                    if (w != v && mu[s][w] != 0 && mask[w]) mu[s][w]--;
                mu[s][v] = US - 1;
                if (mm < SMAX) mm++;
            end
        end else if (iv && pr) begin
            if (hw >= 0 && mask[hw]) begin
                mv[s][hw] = 0; e_inv = 1; e_way = hw;
            end
        end
        if (clr) begin mh = 0; mm = 0; end

        fetch_vld_i = f; inval_vld_i = iv; addr_i = a[AW-1:0];
        present_i = pr; enable_i = en; way_en_i = mask; stat_clr_i = clr;
        @(posedge clk);
        #1;
        chk(rsp_vld_o, e_vld, {tg, " R2 response valid"});
        chk(rsp_hit_o, e_hit, {tg, " R3 hit flag"});
        chk(inv_done_o, e_inv, {tg, " R7 invalidate done"});
        if (e_way >= 0) chk(rsp_way_o, e_way, {tg, " R3 R4 R5 R6 way"});
        chk(hit_cnt_o, mh, {tg, " R10 hit count"});
        chk(miss_cnt_o, mm, {tg, " R10 miss count"});
        fetch_vld_i = 0; inval_vld_i = 0; stat_clr_i = 0;
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        for (int s = 0; s < NS; s++)
            for (int w = 0; w < NW; w++) begin mv[s][w] = 0; mt[s][w] = 0; mu[s][w] = 0; end
        mh = 0; mm = 0;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        // R9: reset state
        chk(rsp_vld_o, 0, "R9 reset rsp_vld");
        chk(rsp_hit_o, 0, "R9 reset rsp_hit");
        chk(inv_done_o, 0, "R9 reset inv_done");
        chk(hit_cnt_o, 0, "R9 reset hit count");
        chk(miss_cnt_o, 0, "R9 reset miss count");

        // R5: empty set fills invalid ways lowest first
        for (int k = 1; k <= 4; k++)
            run_op(1, 0, mk_addr(k, 0, 0), 1, 1, 4'hF, 0, "R5 fill");
        // R1: same tag, other set misses
        run_op(1, 0, mk_addr(1, 1, 4), 1, 1, 4'hF, 0, "R1 other set");
        // R3 R4: hit in set 0 at way 0
        run_op(1, 0, mk_addr(1, 0, 8), 1, 1, 4'hF, 0, "R3 R4 hit");
        // R5: smallest counter is victim
        run_op(1, 0, mk_addr(5, 0, 0), 1, 1, 4'hF, 0, "R4 R5 victim");
        // R6: masked ways keep their counters on misses
        run_op(1, 0, mk_addr(6, 0, 0), 1, 1, 4'h0, 0, "R6 mask none");
        run_op(1, 0, mk_addr(7, 0, 0), 1, 1, 4'h0, 0, "R6 mask none");
        run_op(1, 0, mk_addr(8, 0, 0), 1, 1, 4'h5, 0, "R6 mask partial");
        // R2: disabled or absent fetch ignored, state unchanged
        run_op(1, 0, mk_addr(9, 0, 0), 1, 0, 4'hF, 0, "R2 disabled");
        run_op(1, 0, mk_addr(9, 0, 0), 0, 1, 4'hF, 0, "R2 absent");
        run_op(1, 0, mk_addr(8, 0, 0), 1, 1, 4'hF, 0, "R2 after ignore");
        // R7: invalidate gated by mask, allowed while disabled, not while absent
        run_op(0, 1, mk_addr(8, 0, 0), 1, 1, 4'h0, 0, "R7 masked off");
        run_op(0, 1, mk_addr(8, 0, 0), 0, 1, 4'hF, 0, "R7 absent");
        run_op(0, 1, mk_addr(8, 0, 0), 1, 0, 4'hF, 0, "R7 disabled ok");
        run_op(1, 0, mk_addr(8, 0, 0), 1, 1, 4'hF, 0, "R7 refetch miss");
        // R8: fetch wins over invalidate
        run_op(1, 1, mk_addr(8, 0, 0), 1, 1, 4'hF, 0, "R8 both");
        run_op(1, 0, mk_addr(8, 0, 0), 1, 1, 4'hF, 0, "R8 still valid");
        // R10: clear wins over same-cycle increment
        run_op(1, 0, mk_addr(8, 0, 0), 1, 1, 4'hF, 1, "R10 clear");

        // Constrained random mix
        void'($urandom(32'd20240611));
        for (int i = 0; i < 3000; i++) begin
            int r, tgv, stv;
            bit f, iv, pr, en, cl;
            bit [NW-1:0] mk;
            r   = $urandom;
            tgv = $urandom_range(0, 7);
            stv = $urandom_range(0, NS - 1);
            f   = (r % 4) != 0;
            iv  = ((r >> 3) % 5) == 0;
            pr  = ((r >> 6) % 16) != 0;
            en  = ((r >> 10) % 12) != 0;
            cl  = (i < 2000) ? (((r >> 14) % 97) == 0) : 1'b0;
            mk  = (((r >> 20) % 4) == 0) ? NW'($urandom) : '1;
            run_op(f, iv, mk_addr(tgv, stv, r >> 24), pr, en, mk, cl, "rand R1 R8");
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule